// File: doc/BRIEF.md
# Read-Sequence Write-Protect Tracker

This block holds the software write-protect state of a byte-wide flash array. It leaves protection on after power-up. It changes that state only when it sees a fixed run of seven consecutive read cycles at set addresses. Two runs are defined. They share their first six addresses (1823h, 1820h, 1822h, 0418h, 041Bh, 0419h) and differ only in the seventh. A seventh read at 041Ah drops protection, and a seventh read at 040Ah raises it again. The data bus plays no part in either run, so the block has no data input.

The block watches a read strobe, a write strobe, a chip-enable qualifier and the address bus. It drives a protect flag and a write-grant signal. Erase and program logic downstream uses the write-grant to decide whether a write cycle may start. A write is granted only when the chip is enabled, the write strobe is active and protection is off. A write cycle also throws away any partial progress through a run.

Top module: `prot_read_unlock`

## Requirements
- R1: The synchronous active-low reset sets the protect flag to 1 and discards any partial progress through a run, so a single read of a seventh address right after reset changes nothing.
- R2: Seven reads with chip enable at 1823h, 1820h, 1822h, 0418h, 041Bh, 0419h, 041Ah in that order clear the protect flag. The flag reads 0 from the clock edge that samples the seventh read.
- R3: Seven reads with chip enable at 1823h, 1820h, 1822h, 0418h, 041Bh, 0419h, 040Ah in that order set the protect flag to 1. The flag reads 1 from the clock edge that samples the seventh read.
- R4: A read at an address that does not fit the next step restarts matching. If that address is 1823h, it counts as step one of a new run.
- R5: A write cycle (chip enable and write strobe both high) restarts matching, including when it arrives in the same cycle as a read.
- R6: A cycle with chip enable low, or a cycle with chip enable high but no strobe active, leaves both the matching progress and the protect flag unchanged.
- R7: The write-grant output is high only when chip enable and the write strobe are both high and the protect flag is 0.
- R8: Every address bit takes part in the compare. An address whose upper bits are not zero never matches a step.
- R9: The flag holds its value until the opposite run completes or a reset occurs. Repeating the run that produced the current state, or ending a run with any seventh address other than 041Ah or 040Ah, leaves the flag unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset, used as the power-on reset |
| chip_en | input | 1 | Chip enable; low marks the cycle as a non-access |
| rd_stb | input | 1 | Read strobe for this cycle |
| wr_stb | input | 1 | Write strobe for this cycle |
| addr | input | ADDR_W | Address of the current access |
| prot_on | output | 1 | Protect flag, 1 while erase and program are blocked |
| wr_grant | output | 1 | High when the current write cycle may proceed |

## Verification
The bench builds the block with the default address width of 19 bits, the width of a 512K-byte array. This leaves six address bits above the 13-bit pattern codes. A pattern code with one of those upper bits set can therefore be driven and shown never to match a step. The bench covers both the unprotect and protect runs, and runs broken by a write, by a stray address or by a repeated first address. It also drives reads with chip enable low and idle cycles inside a run, and a reset that arrives part-way through a run.

// File: rtl/prot_seq_pkg.sv
// Package: step addresses for the protect/unprotect read runs.
// Assumes the address bus is at least 13 bits wide so every code fits.
package prot_seq_pkg;

    // number of steps the two runs share before the deciding read
    localparam int PREFIX_LEN = 6;
    // width of the stored address codes
    localparam int CODE_W     = 16;

    // seventh address that clears protection
    localparam logic [CODE_W-1:0] TAIL_UNPROT = 16'h041A;
    // seventh address that sets protection
    localparam logic [CODE_W-1:0] TAIL_PROT   = 16'h040A;

    // Returns the address expected at shared step idx (0-based).
    function automatic logic [CODE_W-1:0] prefix_code(input int idx);
        case (idx)
            0:       prefix_code = 16'h1823;
            1:       prefix_code = 16'h1820;
            2:       prefix_code = 16'h1822;
            3:       prefix_code = 16'h0418;
            4:       prefix_code = 16'h041B;
            5:       prefix_code = 16'h0419;
            default: prefix_code = '0;
        endcase
    endfunction

endpackage

// File: rtl/prot_step_match.sv
// Module: prot_step_match
// Compares the current address against every step code in parallel.
// hit_vec[i] is high when addr equals shared step i. Entries from
// PREFIX_LEN up to 2**CNT_W-1 are tied low, so a full-range count can
// index the vector safely. Assumes ADDR_W >= 13.
module prot_step_match
    import prot_seq_pkg::*;
#(
    parameter int ADDR_W = 19,
    parameter int CNT_W  = 3
) (
    input  logic [ADDR_W-1:0]     addr,
    output logic [(1<<CNT_W)-1:0] hit_vec,
    output logic                  hit_unprot,
    output logic                  hit_prot
);
    localparam int VEC_N = 1 << CNT_W;

    // one comparator per shared step, padding beyond the prefix
    for (genvar i = 0; i < VEC_N; i++) begin : g_step
        if (i < PREFIX_LEN) begin : g_cmp
            assign hit_vec[i] = (addr == ADDR_W'(prefix_code(i)));
        end else begin : g_pad
            assign hit_vec[i] = 1'b0;
        end
    end

    // the two deciding seventh-step compares
    assign hit_unprot = (addr == ADDR_W'(TAIL_UNPROT));
    assign hit_prot   = (addr == ADDR_W'(TAIL_PROT));

endmodule

// File: rtl/prot_seq_counter.sv
// Module: prot_seq_counter
// Counts how many shared steps have matched (0..PREFIX_LEN). It raises
// a one-cycle fire signal on the read that completes either run. A
// write cycle clears the count. A read with no enable, or an idle
// cycle, leaves it alone. Assumes hit inputs describe the current addr.
module prot_seq_counter
    import prot_seq_pkg::*;
#(
    parameter int CNT_W = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  rd_cyc,
    input  logic                  wr_cyc,
    input  logic [(1<<CNT_W)-1:0] hit_vec,
    input  logic                  hit_unprot,
    input  logic                  hit_prot,
    output logic [CNT_W-1:0]      step_cnt,
    output logic                  fire_unprot,
    output logic                  fire_prot
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(PREFIX_LEN);

    logic            at_last;
    logic [CNT_W-1:0] cnt_nxt;

    assign at_last     = (step_cnt == LAST);
    // completion events, only on a clean read at the final step
    assign fire_unprot = rd_cyc && !wr_cyc && at_last && hit_unprot;
    assign fire_prot   = rd_cyc && !wr_cyc && at_last && hit_prot;

    // next-count selection: write restarts, reads advance or restart
    always_comb begin
        cnt_nxt = step_cnt;
        if (wr_cyc) begin
            cnt_nxt = '0;
        end else if (rd_cyc) begin
            if (at_last && (hit_unprot || hit_prot)) begin
                cnt_nxt = '0;
            end else if (!at_last && hit_vec[step_cnt]) begin
                cnt_nxt = step_cnt + 1'b1;
            end else if (hit_vec[0]) begin
                cnt_nxt = CNT_W'(1);
            end else begin
                cnt_nxt = '0;
            end
        end
    end

    // progress register with synchronous reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step_cnt <= '0;
        end else begin
            step_cnt <= cnt_nxt;
        end
    end

endmodule

// File: rtl/prot_read_unlock.sv
// Module: prot_read_unlock (top)
// Tracks the software write-protect state from the read-address runs
// and gates write cycles with it. Protection is on after reset. Assumes
// one access per clock, qualified by chip_en.
module prot_read_unlock
    import prot_seq_pkg::*;
#(
    parameter int ADDR_W = 19
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chip_en,
    input  logic              rd_stb,
    input  logic              wr_stb,
    input  logic [ADDR_W-1:0] addr,
    output logic              prot_on,
    output logic              wr_grant
);
    localparam int CNT_W = $clog2(PREFIX_LEN + 1);

    logic                  rd_cyc;
    logic                  wr_cyc;
    logic [(1<<CNT_W)-1:0] hit_vec;
    logic                  hit_unprot;
    logic                  hit_prot;
    logic [CNT_W-1:0]      step_cnt;
    logic                  fire_unprot;
    logic                  fire_prot;

    // qualified access cycles
    assign rd_cyc = chip_en && rd_stb;
    assign wr_cyc = chip_en && wr_stb;

    prot_step_match #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) match_i (
        .addr       (addr),
        .hit_vec    (hit_vec),
        .hit_unprot (hit_unprot),
        .hit_prot   (hit_prot)
    );

    prot_seq_counter #(.CNT_W(CNT_W)) count_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .rd_cyc      (rd_cyc),
        .wr_cyc      (wr_cyc),
        .hit_vec     (hit_vec),
        .hit_unprot  (hit_unprot),
        .hit_prot    (hit_prot),
        .step_cnt    (step_cnt),
        .fire_unprot (fire_unprot),
        .fire_prot   (fire_prot)
    );

    // protect flag: set by reset or the protect run, cleared by unprotect run
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prot_on <= 1'b1;
        end else if (fire_unprot) begin
            prot_on <= 1'b0;
        end else if (fire_prot) begin
            prot_on <= 1'b1;
        end
    end

    // write gating toward erase/program logic
    assign wr_grant = wr_cyc && !prot_on;

endmodule

// File: rtl/prot_read_unlock_chk.sv
// Module: prot_read_unlock_chk
// Temporal checks on the protect tracker, bound into every instance.
// Assumes step_cnt is the tracker's progress count (0..6).
module prot_read_unlock_chk #(
    parameter int ADDR_W = 19,
    parameter int CNT_W  = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              chip_en,
    input logic              rd_stb,
    input logic              wr_stb,
    input logic [ADDR_W-1:0] addr,
    input logic              prot_on,
    input logic              wr_grant,
    input logic [CNT_W-1:0]  step_cnt
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(6);

    // reset leaves protection on and progress cleared
    assert_reset_state_R1: assert property (@(posedge clk)
        !rst_n |=> (prot_on && step_cnt == '0));

    // protection only drops after the seventh unprotect read
    assert_unprot_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(prot_on) |-> $past(chip_en && rd_stb && !wr_stb
                                 && addr == ADDR_W'(16'h041A) && step_cnt == LAST));

    // protection only rises after the seventh protect read
    assert_prot_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(prot_on) |-> $past(chip_en && rd_stb && !wr_stb
                                 && addr == ADDR_W'(16'h040A) && step_cnt == LAST));

    // progress never exceeds the shared prefix length
    assert_cnt_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        step_cnt <= LAST);

    // a write cycle discards progress
    assert_write_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (chip_en && wr_stb) |=> step_cnt == '0);

    // non-access cycles change nothing
    assert_idle_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(chip_en && (rd_stb || wr_stb)) |=> ($stable(step_cnt) && $stable(prot_on)));

    // a granted write never coincides with a protected state
    assert_grant_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_grant |-> (!prot_on && chip_en && wr_stb));

endmodule

bind prot_read_unlock prot_read_unlock_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .chip_en  (chip_en),
    .rd_stb   (rd_stb),
    .wr_stb   (wr_stb),
    .addr     (addr),
    .prot_on  (prot_on),
    .wr_grant (wr_grant),
    .step_cnt (step_cnt)
);

// File: tb/prot_read_unlock_tb_top.sv
// Bench: table-driven walk through runs, then directed reset and
// address-width cases. Inputs change on the falling edge.
module prot_read_unlock_tb_top;
    localparam int ADDR_W = 19;
    localparam int NV     = 55;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              chip_en;
    logic              rd_stb;
    logic              wr_stb;
    logic [ADDR_W-1:0] addr;
    logic              prot_on;
    logic              wr_grant;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    prot_read_unlock #(.ADDR_W(ADDR_W)) dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .chip_en  (chip_en),
        .rd_stb   (rd_stb),
        .wr_stb   (wr_stb),
        .addr     (addr),
        .prot_on  (prot_on),
        .wr_grant (wr_grant)
    );

    // vector: {rd, wr, ce, addr16, exp_grant, exp_prot_after, req}
    localparam logic [24:0] VEC [NV] = '{
        // R7: write while protected is refused
        {3'b011, 16'h0000, 2'b01, 4'd7},
        // R2: unprotect run
        {3'b101, 16'h1823, 2'b01, 4'd2}, {3'b101, 16'h1820, 2'b01, 4'd2},
        {3'b101, 16'h1822, 2'b01, 4'd2}, {3'b101, 16'h0418, 2'b01, 4'd2},
        {3'b101, 16'h041B, 2'b01, 4'd2}, {3'b101, 16'h0419, 2'b01, 4'd2},
        {3'b101, 16'h041A, 2'b00, 4'd2},
        // R7: granted write, then strobe without enable, then idle
        {3'b011, 16'h0000, 2'b10, 4'd7}, {3'b010, 16'h0000, 2'b00, 4'd7},
        {3'b001, 16'h0000, 2'b00, 4'd7},
        // R5: write inside a protect run breaks it
        {3'b101, 16'h1823, 2'b00, 4'd5}, {3'b101, 16'h1820, 2'b00, 4'd5},
        {3'b011, 16'h0000, 2'b10, 4'd5}, {3'b101, 16'h1822, 2'b00, 4'd5},
        {3'b101, 16'h0418, 2'b00, 4'd5}, {3'b101, 16'h041B, 2'b00, 4'd5},
        {3'b101, 16'h0419, 2'b00, 4'd5}, {3'b101, 16'h040A, 2'b00, 4'd5},
        // R3 with R6 gaps: disabled read and idle inside the run
        {3'b101, 16'h1823, 2'b00, 4'd3}, {3'b101, 16'h1820, 2'b00, 4'd3},
        {3'b100, 16'hFFFF, 2'b00, 4'd6}, {3'b001, 16'h0000, 2'b00, 4'd6},
        {3'b101, 16'h1822, 2'b00, 4'd3}, {3'b101, 16'h0418, 2'b00, 4'd3},
        {3'b101, 16'h041B, 2'b00, 4'd3}, {3'b101, 16'h0419, 2'b00, 4'd3},
        {3'b101, 16'h040A, 2'b01, 4'd3},
        // R9: repeating the protect run keeps the flag
        {3'b101, 16'h1823, 2'b01, 4'd9}, {3'b101, 16'h1820, 2'b01, 4'd9},
        {3'b101, 16'h1822, 2'b01, 4'd9}, {3'b101, 16'h0418, 2'b01, 4'd9},
        {3'b101, 16'h041B, 2'b01, 4'd9}, {3'b101, 16'h0419, 2'b01, 4'd9},
        {3'b101, 16'h040A, 2'b01, 4'd9},
        // R9: wrong seventh address, then a lone tail read
        {3'b101, 16'h1823, 2'b01, 4'd9}, {3'b101, 16'h1820, 2'b01, 4'd9},
        {3'b101, 16'h1822, 2'b01, 4'd9}, {3'b101, 16'h0418, 2'b01, 4'd9},
        {3'b101, 16'h041B, 2'b01, 4'd9}, {3'b101, 16'h0419, 2'b01, 4'd9},
        {3'b101, 16'h041C, 2'b01, 4'd9}, {3'b101, 16'h041A, 2'b01, 4'd9},
        // R4: repeated first address restarts as step one
        {3'b101, 16'h1823, 2'b01, 4'd4}, {3'b101, 16'h1820, 2'b01, 4'd4},
        {3'b101, 16'h1823, 2'b01, 4'd4}, {3'b101, 16'h1820, 2'b01, 4'd4},
        {3'b101, 16'h1822, 2'b01, 4'd4}, {3'b101, 16'h0418, 2'b01, 4'd4},
        {3'b101, 16'h041B, 2'b01, 4'd4}, {3'b101, 16'h0419, 2'b01, 4'd4},
        {3'b101, 16'h041A, 2'b00, 4'd4},
        // R4: stray address mid-run discards progress
        {3'b101, 16'h1823, 2'b00, 4'd4}, {3'b101, 16'h1111, 2'b00, 4'd4},
        {3'b101, 16'h1820, 2'b00, 4'd4}
    };

    // Record one comparison.
    task automatic check(input logic act, input logic exp, input string what);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b", what, act, exp);
        end
    endtask

    // Drive one cycle at a falling edge; check grant now, flag after the edge.
    task automatic apply(input logic r, input logic w, input logic c,
                         input logic [ADDR_W-1:0] a, input logic eg,
                         input logic ep, input string tag);
        rd_stb = r; wr_stb = w; chip_en = c; addr = a;
        #1;
        check(wr_grant, eg, {tag, " wr_grant"});
        @(negedge clk);
        check(prot_on, ep, {tag, " prot_on"});
    endtask

    // Pulse reset for two cycles, ending on a falling edge.
    task automatic do_reset();
        rd_stb = 0; wr_stb = 0; chip_en = 0; addr = '0; rst_n = 0;
        repeat (2) @(negedge clk);
        rst_n = 1;
    endtask

    // Drive the six shared steps.
    task automatic prefix(input logic ep, input string tag);
        apply(1, 0, 1, 19'h01823, 0, ep, tag);
        apply(1, 0, 1, 19'h01820, 0, ep, tag);
        apply(1, 0, 1, 19'h01822, 0, ep, tag);
        apply(1, 0, 1, 19'h00418, 0, ep, tag);
        apply(1, 0, 1, 19'h0041B, 0, ep, tag);
        apply(1, 0, 1, 19'h00419, 0, ep, tag);
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        rst_n = 0; chip_en = 0; rd_stb = 0; wr_stb = 0; addr = '0;
        @(negedge clk);
        do_reset();
        check(prot_on, 1'b1, "R1 reset state");

        for (int i = 0; i < NV; i++) begin
            apply(VEC[i][24], VEC[i][23], VEC[i][22], ADDR_W'(VEC[i][21:6]),
                  VEC[i][5], VEC[i][4], $sformatf("R%0d vec %0d", VEC[i][3:0], i));
        end

        // R8: first step with an upper address bit set does not match
        apply(1, 0, 1, 19'h41823, 0, 0, "R8 high bit");
        apply(1, 0, 1, 19'h01820, 0, 0, "R8");
        apply(1, 0, 1, 19'h01822, 0, 0, "R8");
        apply(1, 0, 1, 19'h00418, 0, 0, "R8");
        apply(1, 0, 1, 19'h0041B, 0, 0, "R8");
        apply(1, 0, 1, 19'h00419, 0, 0, "R8");
        apply(1, 0, 1, 19'h0040A, 0, 0, "R8 no protect");
        // R8: upper bit on the tail also misses, then the true tail hits
        prefix(0, "R8 prefix");
        apply(1, 0, 1, 19'h2040A, 0, 0, "R8 tail high bit");
        prefix(0, "R8 prefix");
        apply(1, 0, 1, 19'h0040A, 0, 1, "R8 clean tail");

        // R5: write in the same cycle as the seventh read cancels it
        prefix(1, "R5 prefix");
        apply(1, 1, 1, 19'h0041A, 0, 1, "R5 read+write tail");

        // R1: reset mid-run discards progress
        prefix(1, "R1 prefix");
        do_reset();
        check(prot_on, 1'b1, "R1 after mid-run reset");
        apply(1, 0, 1, 19'h0041A, 0, 1, "R1 lone tail");

        // R1: reset from the unprotected state
        prefix(1, "R1 prefix");
        apply(1, 0, 1, 19'h0041A, 0, 0, "R1 unprotect");
        do_reset();
        check(prot_on, 1'b1, "R1 reprotect on reset");
        apply(0, 1, 1, 19'h00000, 0, 1, "R1 R7 write refused");

        summary();
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
    end

endmodule